// File: doc/BRIEF.md
# NAND one-bit ECC generator and corrector

This block computes a single-error-correcting parity code over a 512-byte chunk of NAND data that arrives one byte per clock. It keeps two 12-bit parity halves. One half is the XOR of the bit address (byte index times eight plus bit index) of every data bit that is one. The other half is the XOR of the complements of those addresses. The 24-bit code is the bitwise inverse of the two halves side by side. A fully erased chunk (all bytes 0xFF) therefore yields 0xFFFFFF, which is exactly what erased spare bytes read back as. When stored in flash, the code is laid out as three bytes, least significant byte first.

On the write path the caller takes the code when the code strobe pulses. On the read path the caller presents the code it read from the spare area during that same strobe cycle. The block XORs that stored code with the freshly computed one and classifies the result in the following cycle. The result is clean, one data bit to flip (given by byte index and bit index), one flipped check bit needing no data change, or uncorrectable. The result is held until the next chunk begins. Applying the flip to the page buffer is left to the caller.

Top module: `nand_ecc1`

## Requirements
- R1: After reset, code_valid_o and result_valid_o are 0, status_o is 0, fix_en_o is 0, and code_o reads 0xFFFFFF.
- R2: A cycle with chunk_start_i high discards any partial chunk. If byte_valid_i is high in that cycle, that byte is counted as byte 0 of the new chunk.
- R3: code_valid_o is high for exactly one cycle. That cycle is the one right after the clock edge that accepts the 512th byte of a chunk.
- R4: code_o[23:12] is the inverse of the XOR, over every one-bit of the chunk, of the 12-bit address {byte index[8:0], bit index[2:0]}. code_o[11:0] is the inverse of the XOR of the complements of those addresses. An all-0xFF chunk gives 0xFFFFFF.
- R5: Bytes offered after the 512th without a new chunk_start_i are ignored. code_o and the held result stay unchanged.
- R6: If stored_code_i equals code_o in the code_valid_o cycle, the result is status 0 (clean) with fix_en_o low.
- R7: Let d be code_o XOR stored_code_i. If d[23:12] XOR d[11:0] is 0xFFF, the result is status 1 (corrected) with fix_en_o high, fix_byte_o = d[23:15] and fix_bit_o = d[14:12]. If that byte index is not below the chunk length, the result is status 2 instead.
- R8: If d has exactly one bit set, the result is status 1 with fix_en_o low. The flipped bit is in the stored code and the data needs no change.
- R9: Any other nonzero d gives status 2 (uncorrectable) with fix_en_o low. Status value 3 never appears.
- R10: The result is latched at the edge that ends the code_valid_o cycle, so result_valid_o rises in the next cycle. It is held while no chunk starts. A chunk_start_i outside a code_valid_o cycle clears result_valid_o, status_o and fix_en_o at the next edge.
- R11: Cycles with byte_valid_i low neither count nor change the parity.
- R12: If chunk_start_i arrives in the code_valid_o cycle, the finished chunk's result is still latched and held, and the new chunk's first byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chunk_start_i | input | 1 | Begins a new chunk; marks byte 0 when byte_valid_i is high |
| byte_valid_i | input | 1 | byte_i carries a data byte this cycle |
| byte_i | input | 8 | Data byte |
| stored_code_i | input | 24 | Code read back from flash, sampled in the code_valid_o cycle |
| code_o | output | 24 | Current code of the chunk; final while code_valid_o is high |
| code_valid_o | output | 1 | One-cycle pulse after the last byte of a chunk |
| result_valid_o | output | 1 | Classification below is valid |
| status_o | output | 2 | 0 clean, 1 corrected, 2 uncorrectable |
| fix_en_o | output | 1 | A data bit must be flipped |
| fix_byte_o | output | 9 | Byte index of the bit to flip |
| fix_bit_o | output | 3 | Bit index within that byte |

## Verification
Two events can fall in one cycle: the latching of a finished chunk's classification and the start of the next chunk, which both clears the parity and accepts a first byte. The bench provokes this by driving the first byte of a new chunk, with chunk_start_i, in the code_valid_o cycle of a chunk that carries one flipped data bit. It judges the case on three points: the correction for the first chunk must appear and be held, the second chunk's code must match a model computed only from its own bytes, and the second chunk's result must then replace the first.

// File: rtl/nand_ecc1_pkg.sv
// Shared widths and status encoding for the one-bit NAND ECC block.
// Assumes chunks of at most 512 bytes, so a byte index fits in 9 bits.
package nand_ecc1_pkg;
    localparam int IDX_W  = 9;
    localparam int BIT_W  = 3;
    localparam int HALF_W = IDX_W + BIT_W;
    localparam int CODE_W = 2 * HALF_W;

    typedef enum logic [1:0] {
        ST_CLEAN = 2'd0,
        ST_FIXED = 2'd1,
        ST_BAD   = 2'd2
    } ecc_status_t;
endpackage

// File: rtl/ecc1_contrib.sv
// Parity contribution of one byte: XOR of the bit addresses of its set bits
// (high half) and of their complements (low half). Purely combinational.
module ecc1_contrib
    import nand_ecc1_pkg::*;
(
    input  logic [7:0]        data_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [HALF_W-1:0] hi_o,
    output logic [HALF_W-1:0] lo_o
);
    logic [HALF_W-1:0] hi_t [8];
    logic [HALF_W-1:0] lo_t [8];

    genvar b;
    generate
        for (b = 0; b < 8; b++) begin : g_bit
            // address term of bit b when it is set
            assign hi_t[b] = data_i[b] ? {idx_i, BIT_W'(b)} : '0;
            assign lo_t[b] = data_i[b] ? ~{idx_i, BIT_W'(b)} : '0;
        end
    endgenerate

    // fold the eight terms into one contribution per half
    always_comb begin
        hi_o = '0;
        lo_o = '0;
        for (int k = 0; k < 8; k++) begin
            hi_o = hi_o ^ hi_t[k];
            lo_o = lo_o ^ lo_t[k];
        end
    end
endmodule

// File: rtl/ecc1_accum.sv
// Counts the bytes of a chunk and accumulates the two parity halves.
// Pulses code_valid_o one cycle after the last byte; bytes after the last
// are ignored until the next chunk start. Assumes 2 <= CHUNK_BYTES <= 512.
module ecc1_accum
    import nand_ecc1_pkg::*;
#(
    parameter int CHUNK_BYTES = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chunk_start_i,
    input  logic              byte_valid_i,
    input  logic [7:0]        byte_i,
    output logic [CODE_W-1:0] code_o,
    output logic              code_valid_o
);
    localparam int CNT_W = $clog2(CHUNK_BYTES + 1);

    logic [CNT_W-1:0]  count;
    logic [HALF_W-1:0] hi_q, lo_q;
    logic [HALF_W-1:0] hi_c, lo_c;
    logic [IDX_W-1:0]  idx;
    logic              done;
    logic              take;

    assign done = (count == CNT_W'(CHUNK_BYTES));
    assign take = byte_valid_i && !done;
    assign idx  = chunk_start_i ? '0 : IDX_W'(count);

    ecc1_contrib u_contrib (
        .data_i (byte_i),
        .idx_i  (idx),
        .hi_o   (hi_c),
        .lo_o   (lo_c)
    );

    // byte counter, parity halves and end-of-chunk pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count        <= '0;
            hi_q         <= '0;
            lo_q         <= '0;
            code_valid_o <= 1'b0;
        end else begin
            code_valid_o <= 1'b0;
            if (chunk_start_i) begin
                count <= byte_valid_i ? CNT_W'(1) : '0;
                hi_q  <= byte_valid_i ? hi_c : '0;
                lo_q  <= byte_valid_i ? lo_c : '0;
            end else if (take) begin
                count        <= count + CNT_W'(1);
                hi_q         <= hi_q ^ hi_c;
                lo_q         <= lo_q ^ lo_c;
                code_valid_o <= (count == CNT_W'(CHUNK_BYTES - 1));
            end
        end
    end

    // stored form is inverted so that erased flash matches
    assign code_o = ~{hi_q, lo_q};

    p_count_bound_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(CHUNK_BYTES));

    p_done_frozen_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        done && !chunk_start_i |=> $stable(code_o));

    p_pulse_single_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        code_valid_o |=> !code_valid_o);

    p_pulse_at_end_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        code_valid_o |-> done);

    p_idle_no_change_r11 : assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid_i && !chunk_start_i |=> $stable(code_o));
endmodule

// File: rtl/ecc1_classify.sv
// Compares a computed code with a stored one and classifies the difference:
// clean, single data bit (with its location), single check bit, or
// uncorrectable. Purely combinational.
module ecc1_classify
    import nand_ecc1_pkg::*;
#(
    parameter int CHUNK_BYTES = 512
) (
    input  logic [CODE_W-1:0] calc_i,
    input  logic [CODE_W-1:0] stored_i,
    output ecc_status_t       status_o,
    output logic              fix_en_o,
    output logic [IDX_W-1:0]  fix_byte_o,
    output logic [BIT_W-1:0]  fix_bit_o
);
    logic [CODE_W-1:0] diff;
    logic              halves_cpl;
    logic              one_bit;
    logic              in_range;

    assign diff       = calc_i ^ stored_i;
    assign halves_cpl = ((diff[CODE_W-1:HALF_W] ^ diff[HALF_W-1:0]) == '1);
    assign one_bit    = (diff != '0) && ((diff & (diff - CODE_W'(1))) == '0);
    assign fix_byte_o = diff[CODE_W-1 -: IDX_W];
    assign fix_bit_o  = diff[HALF_W +: BIT_W];
    assign in_range   = ({1'b0, fix_byte_o} < (IDX_W + 1)'(CHUNK_BYTES));

    // decision tree over the difference pattern
    always_comb begin
        status_o = ST_BAD;
        fix_en_o = 1'b0;
        if (diff == '0) begin
            status_o = ST_CLEAN;
        end else if (halves_cpl) begin
            status_o = in_range ? ST_FIXED : ST_BAD;
            fix_en_o = in_range;
        end else if (one_bit) begin
            status_o = ST_FIXED;
        end
    end
endmodule

// File: rtl/nand_ecc1.sv
// One-bit NAND ECC: streams a chunk through the parity accumulator, then in
// the code strobe cycle compares against the stored code and latches the
// classification, held until the next chunk start. A result latch wins over
// a chunk start that falls in the same cycle.
module nand_ecc1
    import nand_ecc1_pkg::*;
#(
    parameter int CHUNK_BYTES = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chunk_start_i,
    input  logic              byte_valid_i,
    input  logic [7:0]        byte_i,
    input  logic [CODE_W-1:0] stored_code_i,
    output logic [CODE_W-1:0] code_o,
    output logic              code_valid_o,
    output logic              result_valid_o,
    output logic [1:0]        status_o,
    output logic              fix_en_o,
    output logic [IDX_W-1:0]  fix_byte_o,
    output logic [BIT_W-1:0]  fix_bit_o
);
    ecc_status_t      cls_status;
    logic             cls_fix;
    logic [IDX_W-1:0] cls_byte;
    logic [BIT_W-1:0] cls_bit;

    ecc1_accum #(.CHUNK_BYTES(CHUNK_BYTES)) u_accum (
        .clk           (clk),
        .rst_n         (rst_n),
        .chunk_start_i (chunk_start_i),
        .byte_valid_i  (byte_valid_i),
        .byte_i        (byte_i),
        .code_o        (code_o),
        .code_valid_o  (code_valid_o)
    );

    ecc1_classify #(.CHUNK_BYTES(CHUNK_BYTES)) u_classify (
        .calc_i     (code_o),
        .stored_i   (stored_code_i),
        .status_o   (cls_status),
        .fix_en_o   (cls_fix),
        .fix_byte_o (cls_byte),
        .fix_bit_o  (cls_bit)
    );

    // result hold register: latch on code strobe, clear on a later start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_valid_o <= 1'b0;
            status_o       <= ST_CLEAN;
            fix_en_o       <= 1'b0;
            fix_byte_o     <= '0;
            fix_bit_o      <= '0;
        end else if (code_valid_o) begin
            result_valid_o <= 1'b1;
            status_o       <= cls_status;
            fix_en_o       <= cls_fix;
            fix_byte_o     <= cls_fix ? cls_byte : '0;
            fix_bit_o      <= cls_fix ? cls_bit : '0;
        end else if (chunk_start_i) begin
            result_valid_o <= 1'b0;
            status_o       <= ST_CLEAN;
            fix_en_o       <= 1'b0;
            fix_byte_o     <= '0;
            fix_bit_o      <= '0;
        end
    end

    p_result_follows_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        code_valid_o |=> result_valid_o);

    p_clear_on_start_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        chunk_start_i && !code_valid_o |=> !result_valid_o && !fix_en_o);

    p_hold_result_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        !code_valid_o && !chunk_start_i |=> $stable(status_o) && $stable(fix_byte_o));

    p_fix_implies_fixed_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        fix_en_o |-> result_valid_o && status_o == 2'd1);

    p_status_legal_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        status_o != 2'd3);

    p_start_in_pulse_r12 : assert property (@(posedge clk) disable iff (!rst_n)
        code_valid_o && chunk_start_i |=> result_valid_o);
endmodule

// File: tb/sim_nand_ecc1.sv
module sim_nand_ecc1;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam int NB         = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chunk_start_i = 1'b0;
    logic        byte_valid_i = 1'b0;
    logic [7:0]  byte_i = 8'h00;
    logic [23:0] stored_code_i = 24'h0;
    logic [23:0] code_o;
    logic        code_valid_o;
    logic        result_valid_o;
    logic [1:0]  status_o;
    logic        fix_en_o;
    logic [8:0]  fix_byte_o;
    logic [2:0]  fix_bit_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0] buf_q [NB];
    logic [7:0] buf_b [NB];

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_ecc1 u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .chunk_start_i  (chunk_start_i),
        .byte_valid_i   (byte_valid_i),
        .byte_i         (byte_i),
        .stored_code_i  (stored_code_i),
        .code_o         (code_o),
        .code_valid_o   (code_valid_o),
        .result_valid_o (result_valid_o),
        .status_o       (status_o),
        .fix_en_o       (fix_en_o),
        .fix_byte_o     (fix_byte_o),
        .fix_bit_o      (fix_bit_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // expected code straight from the address-XOR definition
    function automatic logic [23:0] model_code(input logic [7:0] d [NB]);
        logic [11:0] h = 12'h0;
        logic [11:0] l = 12'h0;
        for (int i = 0; i < NB; i++)
            for (int b = 0; b < 8; b++)
                if (d[i][b]) begin
                    h = h ^ 12'(i * 8 + b);
                    l = l ^ ~12'(i * 8 + b);
                end
        return ~{h, l};
    endfunction

    task automatic fill(input int seed);
        for (int i = 0; i < NB; i++)
            buf_q[i] = 8'((i * 37 + seed * 11) ^ (i >> 3) ^ (seed << 4));
    endtask

    // stream buf_q; returns positioned in the code strobe cycle
    task automatic drive_chunk(input bit gaps);
        for (int i = 0; i < NB; i++) begin
            if (gaps && (i % 7 == 3)) begin
                @(negedge clk);
                byte_valid_i  = 1'b0;
                chunk_start_i = 1'b0;
                byte_i        = 8'hA5;
            end
            @(negedge clk);
            byte_valid_i  = 1'b1;
            chunk_start_i = (i == 0);
            byte_i        = buf_q[i];
        end
        @(negedge clk);
        byte_valid_i  = 1'b0;
        chunk_start_i = 1'b0;
    endtask

    // in strobe cycle: present stored code, check code, then check result
    task automatic finish_chunk(input string req, input logic [23:0] exp_code,
                                input logic [23:0] stored, input logic [1:0] st,
                                input bit fe, input int fb, input int fbit);
        stored_code_i = stored;
        chk(code_valid_o == 1'b1, "R3", "code strobe", 32'(code_valid_o), 1);
        chk(code_o == exp_code, "R4", "code value", 32'(code_o), 32'(exp_code));
        @(negedge clk);
        chk(code_valid_o == 1'b0, "R3", "strobe one cycle", 32'(code_valid_o), 0);
        chk(result_valid_o == 1'b1, "R10", "result valid", 32'(result_valid_o), 1);
        chk(status_o == st, req, "status", 32'(status_o), 32'(st));
        chk(fix_en_o == fe, req, "fix enable", 32'(fix_en_o), 32'(fe));
        if (fe) begin
            chk(fix_byte_o == 9'(fb), req, "fix byte", 32'(fix_byte_o), 32'(fb));
            chk(fix_bit_o == 3'(fbit), req, "fix bit", 32'(fix_bit_o), 32'(fbit));
        end
    endtask

    task automatic t_reset_r1();
        chk(code_o == 24'hFFFFFF, "R1", "code after reset", 32'(code_o), 32'hFFFFFF);
        chk(code_valid_o == 1'b0, "R1", "strobe after reset", 32'(code_valid_o), 0);
        chk(result_valid_o == 1'b0, "R1", "result after reset", 32'(result_valid_o), 0);
        chk(status_o == 2'd0, "R1", "status after reset", 32'(status_o), 0);
        chk(fix_en_o == 1'b0, "R1", "fix after reset", 32'(fix_en_o), 0);
    endtask

    task automatic t_erased_r4();
        for (int i = 0; i < NB; i++) buf_q[i] = 8'hFF;
        drive_chunk(1'b0);
        finish_chunk("R6", 24'hFFFFFF, 24'hFFFFFF, 2'd0, 1'b0, 0, 0);
    endtask

    task automatic t_clean_r6();
        logic [23:0] g;
        fill(3);
        g = model_code(buf_q);
        drive_chunk(1'b0);
        finish_chunk("R6", g, g, 2'd0, 1'b0, 0, 0);
    endtask

    task automatic t_data_flip_r7(input int seed, input int byte_n, input int bit_n);
        logic [23:0] g, e;
        fill(seed);
        g = model_code(buf_q);
        buf_q[byte_n][bit_n] = ~buf_q[byte_n][bit_n];
        e = model_code(buf_q);
        drive_chunk(1'b0);
        finish_chunk("R7", e, g, 2'd1, 1'b1, byte_n, bit_n);
    endtask

    task automatic t_check_flip_r8(input int pos);
        logic [23:0] g;
        fill(5);
        g = model_code(buf_q);
        drive_chunk(1'b0);
        finish_chunk("R8", g, g ^ (24'h1 << pos), 2'd1, 1'b0, 0, 0);
    endtask

    task automatic t_double_r9();
        logic [23:0] g, e;
        fill(6);
        g = model_code(buf_q);
        buf_q[10][1] = ~buf_q[10][1];
        buf_q[400][6] = ~buf_q[400][6];
        e = model_code(buf_q);
        drive_chunk(1'b0);
        finish_chunk("R9", e, g, 2'd2, 1'b0, 0, 0);
    endtask

    task automatic t_gaps_r11();
        logic [23:0] g;
        fill(8);
        g = model_code(buf_q);
        drive_chunk(1'b1);
        finish_chunk("R11", g, g, 2'd0, 1'b0, 0, 0);
    endtask

    task automatic t_extra_r5();
        logic [23:0] g, e;
        fill(9);
        g = model_code(buf_q);
        buf_q[77][3] = ~buf_q[77][3];
        e = model_code(buf_q);
        drive_chunk(1'b0);
        finish_chunk("R7", e, g, 2'd1, 1'b1, 77, 3);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            byte_valid_i = 1'b1;
            byte_i = 8'h5A + 8'(k);
        end
        @(negedge clk);
        byte_valid_i = 1'b0;
        @(negedge clk);
        chk(code_o == e, "R5", "code after extra bytes", 32'(code_o), 32'(e));
        chk(code_valid_o == 1'b0, "R5", "no strobe on extra", 32'(code_valid_o), 0);
        chk(status_o == 2'd1 && fix_byte_o == 9'd77, "R5", "result kept",
            32'({status_o, fix_byte_o}), 32'({2'd1, 9'd77}));
    endtask

    task automatic t_hold_clear_r10();
        repeat (5) @(negedge clk);
        chk(result_valid_o == 1'b1 && status_o == 2'd1, "R10", "held result",
            32'({result_valid_o, status_o}), 32'({1'b1, 2'd1}));
        chunk_start_i = 1'b1;
        @(negedge clk);
        chunk_start_i = 1'b0;
        chk(result_valid_o == 1'b0, "R10", "cleared valid", 32'(result_valid_o), 0);
        chk(status_o == 2'd0 && fix_en_o == 1'b0, "R10", "cleared status",
            32'({status_o, fix_en_o}), 0);
        chk(code_o == 24'hFFFFFF, "R2", "start without byte clears code", 32'(code_o), 32'hFFFFFF);
    endtask

    task automatic t_restart_r2();
        logic [23:0] g;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            byte_valid_i  = 1'b1;
            chunk_start_i = (i == 0);
            byte_i        = 8'(i * 3 + 1);
        end
        fill(12);
        g = model_code(buf_q);
        drive_chunk(1'b0);
        finish_chunk("R2", g, g, 2'd0, 1'b0, 0, 0);
    endtask

    task automatic t_back_to_back_r12();
        logic [23:0] ga, ea, gb;
        fill(14);
        ga = model_code(buf_q);
        buf_q[256][2] = ~buf_q[256][2];
        ea = model_code(buf_q);
        for (int i = 0; i < NB; i++) buf_b[i] = 8'(i * 13 + 7);
        gb = model_code(buf_b);
        for (int i = 0; i < NB; i++) begin
            @(negedge clk);
            byte_valid_i  = 1'b1;
            chunk_start_i = (i == 0);
            byte_i        = buf_q[i];
        end
        @(negedge clk);
        stored_code_i = ga;
        chunk_start_i = 1'b1;
        byte_valid_i  = 1'b1;
        byte_i        = buf_b[0];
        chk(code_valid_o == 1'b1, "R12", "strobe with start", 32'(code_valid_o), 1);
        chk(code_o == ea, "R12", "first chunk code", 32'(code_o), 32'(ea));
        for (int i = 1; i < NB; i++) begin
            @(negedge clk);
            chunk_start_i = 1'b0;
            byte_i        = buf_b[i];
            if (i == 1) begin
                chk(result_valid_o == 1'b1 && status_o == 2'd1, "R12", "first result latched",
                    32'({result_valid_o, status_o}), 32'({1'b1, 2'd1}));
                chk(fix_byte_o == 9'd256 && fix_bit_o == 3'd2, "R12", "first fix location",
                    32'({fix_byte_o, fix_bit_o}), 32'({9'd256, 3'd2}));
            end
        end
        @(negedge clk);
        byte_valid_i = 1'b0;
        chk(fix_en_o == 1'b1, "R12", "first result held", 32'(fix_en_o), 1);
        finish_chunk("R12", gb, gb, 2'd0, 1'b0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r1();
        t_erased_r4();
        t_clean_r6();
        t_data_flip_r7(4, 300, 5);
        t_data_flip_r7(7, 0, 0);
        t_data_flip_r7(10, 511, 7);
        t_check_flip_r8(0);
        t_check_flip_r8(23);
        t_double_r9();
        t_gaps_r11();
        t_extra_r5();
        t_hold_clear_r10();
        t_restart_r2();
        t_back_to_back_r12();
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R3 watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule